// File: doc/BRIEF.md
# Flash Bus Front End with Read-Mode Multiplexer

This block sits between an asynchronous byte-wide flash bus and the rest of a flash device model that runs in a synchronous clock domain. Each clock it samples the four active-low control pins (chip enable, output enable, write enable and the reset/power-down pin) and classifies the bus cycle as power-down, standby, output disable, read or write. Write cycles are held until the strobe that ends them rises. The address and data are then passed to the command sequencer as a single-cycle beat.

On reads, the block drives one of three sources onto the data bus. The source is set by the read mode that the command sequencer selects: array contents, the status byte, or identifier space. Identifier space is spread over the block bases. Block 0 holds the manufacturer code, the device code and the master lock flag. Every 64-Kbyte block holds its own lock flag at offset 2. Real pad tri-stating is not modelled. An output-enable flag shows when the bus would be driven, and the data output reads zero when it is not.

After reset, or when the power-down pin is released, two timers run. One gates command writes and the other gates read data.

Top module: `flash_bus_front`

## Requirements
- R1: `bus_mode` decodes the pins with this priority. Power-down pin low gives 0 (power-down). Otherwise chip enable high gives 1 (standby). Otherwise write enable low with output enable high gives 4 (write). Otherwise output enable low with write enable high gives 3 (read). Every other combination gives 2 (output disable).
- R2: `dout_en` is 1 only in read mode (3) after recovery has completed. Whenever `dout_en` is 0, `dout` reads 00h.
- R3: A write beat is accepted from the last cycle in which the bus was in write mode. It is committed at the first clock at which write enable or chip enable is seen high, and the power-down pin must still be high at that clock. `wr_valid` then pulses for exactly one cycle, carrying the address and data from that last write-mode cycle.
- R4: Driving output enable low during a would-be write makes the cycle output disable (2). A write whose window is broken by output enable going low before a strobe rises commits nothing.
- R5: While the power-down pin is low, the bus mode is 0, outputs are off, and any write in progress is dropped. The read mode returns to array.
- R6: A write-mode cycle is accepted only once WAKE_CYC clocks with the power-down pin high and reset low have elapsed since reset or since the pin was last low. Earlier write cycles commit nothing.
- R7: `dout_en` stays 0 until RECOV_CYC clocks with the power-down pin high and reset low have elapsed since reset or since the pin was last low.
- R8: The read mode is array after reset. A `rd_sel_valid` pulse loads `rd_sel`, which takes effect from the next cycle: 0 selects array, 1 identifier, 2 status. The value 3 leaves the mode unchanged.
- R9: In array mode, `dout` equals `array_rdata`. `array_addr` always follows `addr`.
- R10: In status mode, `dout` equals `status_in`.
- R11: In identifier mode, block 0 returns MFR_CODE at offset 0 and DEV_CODE at offset 1. At offset 3 it returns the master lock flag in bit 0, with bits 7..1 zero.
- R12: In identifier mode, offset 2 of any block returns that block's lock flag in bit 0, with bits 7..1 zero. Every other identifier location reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| rp_n | input | 1 | Reset/power-down pin, active low |
| addr | input | ADDR_W | Bus address |
| din | input | 8 | Bus write data |
| dout | output | 8 | Read data (00h when not driven) |
| dout_en | output | 1 | Data bus would be driven |
| bus_mode | output | 3 | Decoded bus cycle (R1 encoding) |
| rd_sel_valid | input | 1 | Read-mode load strobe from the sequencer |
| rd_sel | input | 2 | Read mode to load |
| array_addr | output | ADDR_W | Address to the array model |
| array_rdata | input | 8 | Array byte at `array_addr` |
| status_in | input | 8 | Status byte from the sequencer |
| blk_lock | input | NUM_BLK | Per-block lock flags |
| master_lock | input | 1 | Master lock flag |
| wr_valid | output | 1 | Committed write beat |
| wr_addr | output | ADDR_W | Address of the beat |
| wr_data | output | 8 | Data of the beat |

## Verification
The decode is exercised with write cycles ended by write enable rising and by chip enable rising. This shows that either strobe closes the window. A write whose data changes mid-cycle shows that the last value is the one kept. Write attempts with output enable low, and attempts cut off by the power-down pin, are separated from real writes by the absence of a commit. Identifier reads at offsets 0–4 in block 0, and in other blocks with and without a lock, separate the scattered map from a plain per-offset table. Reads taken straight after power-down release show that the recovery gate is separate from the wake gate.

// File: rtl/flash_bus_pkg.sv
package flash_bus_pkg;

    typedef enum logic [2:0] {
        BM_PWRDN   = 3'd0,
        BM_STANDBY = 3'd1,
        BM_OUTDIS  = 3'd2,
        BM_READ    = 3'd3,
        BM_WRITE   = 3'd4
    } bus_mode_e;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_IDENT  = 2'd1,
        RM_STATUS = 2'd2
    } rd_mode_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic rp_n;
    } bus_pins_t;

    localparam int BYTE_W      = 8;
    localparam int ID_OFS_MFR  = 0;
    localparam int ID_OFS_DEV  = 1;
    localparam int ID_OFS_LOCK = 2;
    localparam int ID_OFS_MSTR = 3;

    function automatic bus_mode_e classify(bus_pins_t p);
        if (!p.rp_n)                 return BM_PWRDN;
        else if (p.ce_n)             return BM_STANDBY;
        else if (!p.we_n && p.oe_n)  return BM_WRITE;
        else if (!p.oe_n && p.we_n)  return BM_READ;
        else                         return BM_OUTDIS;
    endfunction

    function automatic logic [BYTE_W-1:0] flag_byte(logic f);
        logic [BYTE_W-1:0] b;
        b    = '0;
        b[0] = f;
        return b;
    endfunction

endpackage

// File: rtl/fbus_mode_decode.sv
module fbus_mode_decode
    import flash_bus_pkg::*;
(
    input  bus_pins_t pins,
    output bus_mode_e mode
);
    always_comb mode = classify(pins);
endmodule

// File: rtl/fbus_ready_timer.sv
module fbus_ready_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    output logic done
);
    generate
        if (LIMIT <= 0) begin : g_none
            assign done = 1'b1;
        end else begin : g_count
            localparam int CW = $clog2(LIMIT + 1);
            logic [CW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst || hold)
                    cnt <= '0;
                else if (cnt != CW'(LIMIT))
                    cnt <= cnt + 1'b1;
            end
            assign done = (cnt == CW'(LIMIT));
        end
    endgenerate
endmodule

// File: rtl/fbus_write_latch.sv
module fbus_write_latch
    import flash_bus_pkg::*;
#(
    parameter int AW = 21,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_mode_e     mode,
    input  logic          wake_ok,
    input  bus_pins_t     pins,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    typedef struct packed {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } beat_t;

    logic  act, act_q, strobe_up;
    beat_t held;

    assign act       = (mode == BM_WRITE) && wake_ok;
    assign strobe_up = act_q && pins.rp_n && (pins.we_n || pins.ce_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q    <= 1'b0;
            held     <= '0;
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_valid <= strobe_up;
            if (strobe_up) begin
                wr_addr <= held.a;
                wr_data <= held.d;
            end
            act_q <= act;
            if (act)
                held <= '{a: addr, d: din};
        end
    end
endmodule

// File: rtl/fbus_read_mux.sv
module fbus_read_mux
    import flash_bus_pkg::*;
#(
    parameter int              AW      = 21,
    parameter int              OFS_W   = 16,
    parameter int              NBLK    = 32,
    parameter logic [7:0]      MFR     = 8'hA7,
    parameter logic [7:0]      DEV     = 8'h3C
) (
    input  bus_mode_e         mode,
    input  rd_mode_e          rd_mode,
    input  logic              rec_ok,
    input  logic [AW-1:0]     addr,
    input  logic [BYTE_W-1:0] array_rdata,
    input  logic [BYTE_W-1:0] status_in,
    input  logic [NBLK-1:0]   blk_lock,
    input  logic              master_lock,
    output logic              dout_en,
    output logic [BYTE_W-1:0] dout
);
    localparam int BW = AW - OFS_W;

    logic [BW-1:0]     blk;
    logic [OFS_W-1:0]  ofs;
    logic [BYTE_W-1:0] id_byte, src;

    assign blk = addr[AW-1:OFS_W];
    assign ofs = addr[OFS_W-1:0];

    always_comb begin
        id_byte = '0;
        if (ofs == OFS_W'(ID_OFS_LOCK))
            id_byte = flag_byte(blk_lock[blk]);
        else if (blk == '0) begin
            if (ofs == OFS_W'(ID_OFS_MFR))
                id_byte = MFR;
            else if (ofs == OFS_W'(ID_OFS_DEV))
                id_byte = DEV;
            else if (ofs == OFS_W'(ID_OFS_MSTR))
                id_byte = flag_byte(master_lock);
        end
    end

    always_comb begin
        unique case (rd_mode)
            RM_IDENT:  src = id_byte;
            RM_STATUS: src = status_in;
            default:   src = array_rdata;
        endcase
    end

    assign dout_en = (mode == BM_READ) && rec_ok;
    assign dout    = dout_en ? src : '0;
endmodule

// File: rtl/flash_bus_front.sv
module flash_bus_front
    import flash_bus_pkg::*;
#(
    parameter int         ADDR_W    = 21,
    parameter int         BLK_OFS_W = 16,
    parameter int         WAKE_CYC  = 4,
    parameter int         RECOV_CYC = 6,
    parameter logic [7:0] MFR_CODE  = 8'hA7,
    parameter logic [7:0] DEV_CODE  = 8'h3C,
    localparam int        NUM_BLK   = 1 << (ADDR_W - BLK_OFS_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ce_n,
    input  logic               oe_n,
    input  logic               we_n,
    input  logic               rp_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [7:0]         din,
    output logic [7:0]         dout,
    output logic               dout_en,
    output logic [2:0]         bus_mode,
    input  logic               rd_sel_valid,
    input  logic [1:0]         rd_sel,
    output logic [ADDR_W-1:0]  array_addr,
    input  logic [7:0]         array_rdata,
    input  logic [7:0]         status_in,
    input  logic [NUM_BLK-1:0] blk_lock,
    input  logic               master_lock,
    output logic               wr_valid,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [7:0]         wr_data
);
    bus_pins_t pins;
    bus_mode_e mode;
    rd_mode_e  rd_mode;
    logic      wake_ok, rec_ok;

    assign pins       = '{ce_n: ce_n, oe_n: oe_n, we_n: we_n, rp_n: rp_n};
    assign bus_mode   = mode;
    assign array_addr = addr;

    fbus_mode_decode u_dec (.pins(pins), .mode(mode));

    fbus_ready_timer #(.LIMIT(WAKE_CYC)) u_wake (
        .clk(clk), .rst(rst), .hold(!rp_n), .done(wake_ok)
    );

    fbus_ready_timer #(.LIMIT(RECOV_CYC)) u_recov (
        .clk(clk), .rst(rst), .hold(!rp_n), .done(rec_ok)
    );

    always_ff @(posedge clk) begin
        if (rst || !rp_n)
            rd_mode <= RM_ARRAY;
        else if (rd_sel_valid && rd_sel != 2'd3)
            rd_mode <= rd_mode_e'(rd_sel);
    end

    fbus_write_latch #(.AW(ADDR_W), .DW(8)) u_wr (
        .clk(clk), .rst(rst), .mode(mode), .wake_ok(wake_ok), .pins(pins),
        .addr(addr), .din(din),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    fbus_read_mux #(
        .AW(ADDR_W), .OFS_W(BLK_OFS_W), .NBLK(NUM_BLK),
        .MFR(MFR_CODE), .DEV(DEV_CODE)
    ) u_rd (
        .mode(mode), .rd_mode(rd_mode), .rec_ok(rec_ok), .addr(addr),
        .array_rdata(array_rdata), .status_in(status_in),
        .blk_lock(blk_lock), .master_lock(master_lock),
        .dout_en(dout_en), .dout(dout)
    );
endmodule

// File: rtl/flash_bus_front_chk.sv
module flash_bus_front_chk #(
    parameter int WAKE_CYC  = 4,
    parameter int RECOV_CYC = 6
) (
    input logic       clk,
    input logic       rst,
    input logic       rp_n,
    input logic [2:0] bus_mode,
    input logic       dout_en,
    input logic       wr_valid
);
    logic [7:0] up_cnt;

    always_ff @(posedge clk) begin
        if (rst || !rp_n)
            up_cnt <= '0;
        else if (up_cnt != 8'hFF)
            up_cnt <= up_cnt + 8'd1;
    end

    // R2: driving implies a read cycle on the bus
    a_r2_drive_in_read: assert property (@(posedge clk) disable iff (rst)
        dout_en |-> bus_mode == 3'd3);

    // R3: a commit lasts one cycle
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid);

    // R3: a commit follows a write-mode cycle two clocks back
    a_r3_after_write: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> $past(bus_mode, 2) == 3'd4);

    // R5: power-down pin low keeps the bus undriven
    a_r5_pd_quiet: assert property (@(posedge clk) disable iff (rst)
        !rp_n |-> !dout_en);

    // R6: no commit before the wake interval
    a_r6_wake_gate: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> int'(up_cnt) >= WAKE_CYC + 2);

    // R7: no drive before recovery
    a_r7_recov_gate: assert property (@(posedge clk) disable iff (rst)
        dout_en |-> int'(up_cnt) >= RECOV_CYC);
endmodule

bind flash_bus_front flash_bus_front_chk #(
    .WAKE_CYC(WAKE_CYC), .RECOV_CYC(RECOV_CYC)
) chk_i (
    .clk(clk), .rst(rst), .rp_n(rp_n), .bus_mode(bus_mode),
    .dout_en(dout_en), .wr_valid(wr_valid)
);

// File: tb/flash_bus_front_tb_top.sv
`timescale 1ns/1ps
module flash_bus_front_tb_top;
    localparam int AW = 21;
    localparam int WAKE = 4;
    localparam int RECOV = 6;
    localparam logic [7:0] MFR = 8'hA7;
    localparam logic [7:0] DEV = 8'h3C;

    logic clk = 0;
    logic rst = 1;
    logic ce_n = 1, oe_n = 1, we_n = 1, rp_n = 1;
    logic [AW-1:0] addr = '0;
    logic [7:0] din = '0;
    logic rd_sel_valid = 0;
    logic [1:0] rd_sel = '0;
    logic [7:0] status_in = 8'h80;
    logic [31:0] blk_lock = 32'h0000_0024;
    logic master_lock = 1;
    logic [7:0] dout, array_rdata, wr_data;
    logic dout_en, wr_valid;
    logic [2:0] bus_mode;
    logic [AW-1:0] array_addr, wr_addr;

    int n_chk = 0, n_err = 0;

    always #5 clk = ~clk;

    function automatic logic [7:0] arr_fn(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ {3'b0, a[20:16]} ^ 8'h5C;
    endfunction

    assign array_rdata = arr_fn(array_addr);

    flash_bus_front dut_i (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .rp_n(rp_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .bus_mode(bus_mode),
        .rd_sel_valid(rd_sel_valid), .rd_sel(rd_sel), .array_addr(array_addr),
        .array_rdata(array_rdata), .status_in(status_in), .blk_lock(blk_lock),
        .master_lock(master_lock), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int          m_up = 0;
    int          m_rmode = 0;
    bit          m_act = 0;
    logic [AW-1:0] m_ha = '0, m_oa = '0;
    logic [7:0]  m_hd = '0, m_od = '0;
    bit          m_valid = 0;

    always @(posedge clk) begin
        bit wake, now_act, commit;
        if (rst) begin
            m_up = 0; m_rmode = 0; m_act = 0; m_valid = 0;
            m_ha = '0; m_hd = '0; m_oa = '0; m_od = '0;
        end else begin
            wake    = (m_up >= WAKE);
            now_act = rp_n && !ce_n && !we_n && oe_n && wake;
            commit  = m_act && rp_n && (we_n || ce_n);
            m_valid = commit;
            if (commit) begin m_oa = m_ha; m_od = m_hd; end
            if (now_act) begin m_ha = addr; m_hd = din; end
            m_act = now_act;
            if (!rp_n) m_up = 0; else if (m_up < 1000) m_up = m_up + 1;
            if (!rp_n) m_rmode = 0;
            else if (rd_sel_valid && rd_sel != 2'd3) m_rmode = int'(rd_sel);
        end
    end

    function automatic int exp_mode();
        if (!rp_n) return 0;
        if (ce_n) return 1;
        if (!we_n && oe_n) return 4;
        if (!oe_n && we_n) return 3;
        return 2;
    endfunction

    function automatic logic [7:0] exp_id(input logic [AW-1:0] a);
        int b, o;
        b = int'(a[20:16]); o = int'(a[15:0]);
        if (o == 2) return {7'b0, blk_lock[b]};
        if (b == 0 && o == 0) return MFR;
        if (b == 0 && o == 1) return DEV;
        if (b == 0 && o == 3) return {7'b0, master_lock};
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        bit en;
        logic [7:0] d;
        string t;
        #4;
        check("R1 bus_mode", 32'(bus_mode), 32'(exp_mode()));
        en = (exp_mode() == 3) && (m_up >= RECOV) && !rst;
        check(m_up < RECOV ? "R7 dout_en" : "R2 dout_en", 32'(dout_en), 32'(en));
        if (!en) begin d = 8'h00; t = "R2 dout idle"; end
        else if (m_rmode == 1) begin d = exp_id(addr); t = "R11 ident dout"; end
        else if (m_rmode == 2) begin d = status_in; t = "R10 status dout"; end
        else begin d = arr_fn(addr); t = "R9 array dout"; end
        check(t, 32'(dout), 32'(d));
        check("R9 array_addr", 32'(array_addr), 32'(addr));
        check("R3 wr_valid", 32'(wr_valid), 32'(m_valid));
        if (m_valid) begin
            check("R3 wr_addr", 32'(wr_addr), 32'(m_oa));
            check("R3 wr_data", 32'(wr_data), 32'(m_od));
        end
    end

    // ---------------- stimulus ----------------
    task automatic bus(input logic c, input logic o, input logic w, input logic r,
                       input logic [AW-1:0] a, input logic [7:0] d);
        ce_n = c; oe_n = o; we_n = w; rp_n = r; addr = a; din = d;
        @(posedge clk); #3;
    endtask

    task automatic idle();
        bus(1, 1, 1, 1, addr, din);
    endtask

    task automatic select(input logic [1:0] m);
        rd_sel = m; rd_sel_valid = 1;
        idle();
        rd_sel_valid = 0;
    endtask

    initial begin
        #(200000 * 10);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) idle();
        check("R2 reset dout_en", 32'(dout_en), 0);
        check("R3 reset wr_valid", 32'(wr_valid), 0);
        rst = 0;

        // R6: write straight after reset is refused
        bus(0, 1, 0, 1, 21'h00123, 8'h77);
        bus(0, 1, 1, 1, 21'h00123, 8'h77);
        check("R6 early write", 32'(wr_valid), 0);
        repeat (8) idle();

        // R9: array read
        bus(0, 0, 1, 1, 21'h12345, 8'h00);
        check("R2 read dout_en", 32'(dout_en), 1);
        check("R9 array read", 32'(dout), 32'(arr_fn(21'h12345)));

        // R3: write ended by write enable, data changed mid-cycle
        bus(0, 1, 0, 1, 21'h0ABCD, 8'h11);
        bus(0, 1, 0, 1, 21'h0ABCD, 8'h22);
        bus(0, 1, 1, 1, 21'h0ABCD, 8'h22);
        check("R3 we commit", 32'(wr_valid), 1);
        check("R3 we addr", 32'(wr_addr), 32'h0ABCD);
        check("R3 we data", 32'(wr_data), 32'h22);
        idle();
        check("R3 one pulse", 32'(wr_valid), 0);

        // R3: write ended by chip enable
        bus(0, 1, 0, 1, 21'h1F000, 8'h5A);
        bus(1, 1, 0, 1, 21'h1F000, 8'h5A);
        check("R3 ce commit", 32'(wr_valid), 1);
        check("R3 ce data", 32'(wr_data), 32'h5A);
        idle();

        // R4: output enable low blocks writes
        bus(0, 0, 0, 1, 21'h00010, 8'h33);
        check("R4 outdis mode", 32'(bus_mode), 2);
        bus(0, 1, 1, 1, 21'h00010, 8'h33);
        check("R4 no commit", 32'(wr_valid), 0);
        bus(0, 1, 0, 1, 21'h00020, 8'h44);
        bus(0, 0, 0, 1, 21'h00020, 8'h44);
        bus(0, 1, 1, 1, 21'h00020, 8'h44);
        check("R4 broken window", 32'(wr_valid), 0);
        idle();

        // R11/R12: identifier map
        select(2'd1);
        bus(0, 0, 1, 1, 21'h00000, 0); check("R11 mfr", 32'(dout), 32'(MFR));
        bus(0, 0, 1, 1, 21'h00001, 0); check("R11 dev", 32'(dout), 32'(DEV));
        bus(0, 0, 1, 1, 21'h00003, 0); check("R11 master", 32'(dout), 32'h01);
        bus(0, 0, 1, 1, 21'h50002, 0); check("R12 lock blk5", 32'(dout), 32'h01);
        bus(0, 0, 1, 1, 21'h30002, 0); check("R12 lock blk3", 32'(dout), 32'h00);
        bus(0, 0, 1, 1, 21'h00002, 0); check("R12 lock blk0", 32'(dout), 32'h00);
        bus(0, 0, 1, 1, 21'h50000, 0); check("R12 blk5 ofs0", 32'(dout), 32'h00);
        bus(0, 0, 1, 1, 21'h00004, 0); check("R12 blk0 ofs4", 32'(dout), 32'h00);
        master_lock = 0;
        bus(0, 0, 1, 1, 21'h00003, 0); check("R11 master clr", 32'(dout), 32'h00);

        // R8/R10: status mode, value 3 ignored
        select(2'd2);
        status_in = 8'hA5;
        bus(0, 0, 1, 1, 21'h00000, 0); check("R10 status", 32'(dout), 32'hA5);
        select(2'd3);
        bus(0, 0, 1, 1, 21'h00000, 0); check("R8 sel3 ignored", 32'(dout), 32'hA5);

        // standby
        bus(1, 0, 1, 1, 21'h00000, 0);
        check("R1 standby mode", 32'(bus_mode), 1);
        check("R2 standby quiet", 32'(dout_en), 0);

        // R5: power-down drops write and restores array mode
        bus(0, 1, 0, 1, 21'h00444, 8'h99);
        bus(0, 1, 0, 0, 21'h00444, 8'h99);
        check("R5 pd mode", 32'(bus_mode), 0);
        check("R5 pd quiet", 32'(dout_en), 0);
        bus(0, 1, 1, 1, 21'h00444, 8'h99);
        check("R5 dropped write", 32'(wr_valid), 0);
        bus(0, 0, 1, 1, 21'h04567, 0);
        check("R7 recovery off", 32'(dout_en), 0);
        repeat (RECOV) bus(0, 0, 1, 1, 21'h04567, 0);
        check("R7 recovery on", 32'(dout_en), 1);
        check("R5 array restored", 32'(dout), 32'(arr_fn(21'h04567)));

        // R6: write after wake works
        bus(0, 1, 0, 1, 21'h0F0F0, 8'hC3);
        bus(0, 1, 1, 1, 21'h0F0F0, 8'hC3);
        check("R6 late write", 32'(wr_valid), 1);
        repeat (3) idle();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule